// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox Controller

This block lets several processors pass 32-bit words to one another through a small register map. It holds a parameterised number of message queues, and each queue is a short hardware FIFO. A write to a queue's message register appends a word. A read of that register removes and returns the oldest word. Per-queue status registers report whether the queue is full and how many words it currently holds.

Each processor (a "user") has its own interrupt output, its own status register and its own enable state. Every queue produces two events for every user: a new-message event when a word is accepted, and a not-full event when a pop frees a slot in a full queue. Status bits are cleared by writing ones to them. A build parameter selects one of two interrupt register layouts. The legacy layout has a single enable register per user, which software updates with read-modify-write. The extended layout has separate enable-set and enable-clear registers.

The bus is a simple word interface with address, write strobe, write data, read strobe and read data. Read data is combinational for the addressed register. A pop takes effect at the clock edge that ends the read cycle.

Top module: `mbox_ctrl`

## Requirements
- R1: The revision register at byte offset 0x000 returns the parameter REV_ID (default 0x00000021), and writes to it have no effect.
- R2: A write to the message register of queue m (offset 0x040 + 4*m) appends the write data to that queue. A read with the read strobe returns the oldest word and removes it, so words come back in the order they were written.
- R3: A queue holds FIFO_DEPTH words (default 4). A push to a full queue is discarded. The fill register of queue m (offset 0x080 + 4*m) reads 1 when the queue is full and 0 otherwise.
- R4: The count register of queue m (offset 0x0C0 + 4*m) returns the number of words held. A pop from an empty queue returns zero and leaves the count at zero.
- R5: An accepted push into queue m sets status bit 2*m of every user.
- R6: A pop from a full queue m sets status bit 2*m+1 of every user. Pops from a queue that is not full leave that bit unchanged.
- R7: Writing a one to a status bit clears it, writing a zero leaves it unchanged, and the register of every other user is unaffected.
- R8: With EXT_LAYOUT=0, user u has its status register at 0x100 + 8*u and its enable register at 0x104 + 8*u. A write to the enable register replaces all of its bits, and a read returns them.
- R9: With EXT_LAYOUT=1, user u has status at 0x104 + 16*u, enable-set at 0x108 + 16*u and enable-clear at 0x10C + 16*u. Ones written to enable-set are ORed in, ones written to enable-clear are removed, and zeros change nothing. Both addresses read back the current enable bits.
- R10: irq_out[u] is high exactly when the status and enable bits of user u overlap in at least one position. It follows a register write from the next cycle on.
- R11: After reset, every queue is empty, every status and enable bit is zero, and every interrupt output is low.
- R12: A word in the register window that no register decodes reads zero and ignores writes. Writes to the fill and count registers have no effect.
- R13: When the read and write strobes both hit the same message register in one cycle, the pop is judged against the count before the cycle. The push is accepted only if the queue was not full before the cycle. A full queue therefore pops, drops the push and raises not-full. An empty queue returns zero, accepts the push and raises new-message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops a message register |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | NUM_USERS | Interrupt line of each user |

## Verification
Only a push and a pop can coincide, and only when both strobes are raised together on one message register, because the bus carries a single address. The bench does this on a full queue and on an empty one, in both layouts. It judges the result by the word returned in that cycle, the count read afterwards, the exact status bits raised for a user whose status was cleared just before, and the words drained afterwards, which must not include a dropped push.

// File: rtl/mbox_pkg.sv
// Package: register offsets and offset helpers shared by the mailbox blocks.
// Assumes byte addressing with 32-bit registers on word boundaries.
package mbox_pkg;
    localparam int unsigned OFS_REV    = 32'h000;
    localparam int unsigned OFS_MSG    = 32'h040;
    localparam int unsigned OFS_FILL   = 32'h080;
    localparam int unsigned OFS_COUNT  = 32'h0C0;
    localparam int unsigned Q_STRIDE   = 4;
    localparam int unsigned LEG_BASE   = 32'h100;
    localparam int unsigned LEG_STRIDE = 8;
    localparam int unsigned EXT_BASE   = 32'h104;
    localparam int unsigned EXT_STRIDE = 16;

    // Status register offset of user u in the selected layout.
    function automatic int unsigned stat_ofs(input bit ext, input int unsigned u);
        return ext ? (EXT_BASE + EXT_STRIDE * u) : (LEG_BASE + LEG_STRIDE * u);
    endfunction

    // Enable (legacy) or enable-set (extended) offset of user u.
    function automatic int unsigned en_ofs(input bit ext, input int unsigned u);
        return ext ? (EXT_BASE + 4 + EXT_STRIDE * u) : (LEG_BASE + 4 + LEG_STRIDE * u);
    endfunction

    // Enable-clear offset of user u (extended layout only).
    function automatic int unsigned clr_ofs(input int unsigned u);
        return EXT_BASE + 8 + EXT_STRIDE * u;
    endfunction
endpackage

// File: rtl/mbox_decode.sv
// Address decoder: turns the byte address into one-hot register hits.
// Assumes exact address match; misaligned or unmapped addresses hit nothing.
// The layout parameter picks which user registers exist.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NQ  = 4,
    parameter int NU  = 2,
    parameter bit EXT = 1'b0,
    parameter int AW  = 9
) (
    input  logic [AW-1:0] addr,
    output logic          rev_hit,
    output logic [NQ-1:0] msg_hit,
    output logic [NQ-1:0] fill_hit,
    output logic [NQ-1:0] cnt_hit,
    output logic [NU-1:0] stat_hit,
    output logic [NU-1:0] en_hit,
    output logic [NU-1:0] clr_hit
);
    // Revision register hit.
    assign rev_hit = (addr == AW'(OFS_REV));

    // Per-queue register hits.
    for (genvar m = 0; m < NQ; m++) begin : g_q
        assign msg_hit[m]  = (addr == AW'(OFS_MSG   + Q_STRIDE * m));
        assign fill_hit[m] = (addr == AW'(OFS_FILL  + Q_STRIDE * m));
        assign cnt_hit[m]  = (addr == AW'(OFS_COUNT + Q_STRIDE * m));
    end

    // Per-user register hits; the clear register exists only in the extended layout.
    for (genvar u = 0; u < NU; u++) begin : g_u
        assign stat_hit[u] = (addr == AW'(stat_ofs(EXT, u)));
        assign en_hit[u]   = (addr == AW'(en_ofs(EXT, u)));
        if (EXT) begin : g_ext
            assign clr_hit[u] = (addr == AW'(clr_ofs(u)));
        end else begin : g_leg
            assign clr_hit[u] = 1'b0;
        end
    end
endmodule

// File: rtl/mbox_fifo.sv
// One message queue: a circular buffer of DEPTH words with a fill counter.
// Assumes push and pop are judged against the count before the edge:
// a push into a full queue is dropped even when a pop happens in the same cycle.
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          empty;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= adv(wp);
            if (pop_ok)  rp <= adv(rp);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end
endmodule

// File: rtl/mbox_user_irq.sv
// Interrupt state of one user: sticky status, enable mask and the irq line.
// Assumes a hardware event wins over a clearing write to the same bit.
// EXT=0: a write to the enable register replaces it; EXT=1: set ORs, clear removes.
module mbox_user_irq #(
    parameter int NB  = 8,
    parameter bit EXT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] evt,
    input  logic          stat_wr,
    input  logic          en_wr,
    input  logic          clr_wr,
    input  logic [NB-1:0] wdata,
    output logic [NB-1:0] status,
    output logic [NB-1:0] enable,
    output logic          irq
);
    logic [NB-1:0] en_next;
    logic [NB-1:0] ack;

    // Bits acknowledged by the current write.
    assign ack = stat_wr ? wdata : '0;

    // Next enable value for the selected layout.
    always_comb begin
        en_next = enable;
        if (en_wr) en_next = EXT ? (enable | wdata) : wdata;
        if (clr_wr) en_next = en_next & ~wdata;
    end

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~ack) | evt;
            enable <= en_next;
        end
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/mbox_ctrl.sv
// Mailbox controller top: register decode, queues, per-user interrupts, read mux.
// Assumes single-cycle register access; read data is combinational and a pop
// happens at the edge that ends a read of a message register.
module mbox_ctrl #(
    parameter int          NUM_QUEUES = 4,
    parameter int          NUM_USERS  = 2,
    parameter int          FIFO_DEPTH = 4,
    parameter bit          EXT_LAYOUT = 1'b0,
    parameter int          ADDR_W     = 9,
    parameter logic [31:0] REV_ID     = 32'h0000_0021
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq_out
);
    localparam int NB = 2 * NUM_QUEUES;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic                                rev_hit;
    logic [NUM_QUEUES-1:0]               msg_hit, fill_hit, cnt_hit;
    logic [NUM_USERS-1:0]                stat_hit, en_hit, clr_hit;
    logic [NUM_QUEUES-1:0]               q_push, q_pop, q_push_ok, q_pop_ok, q_full;
    logic [NUM_QUEUES-1:0][31:0]         q_head;
    logic [NUM_QUEUES-1:0][CW-1:0]       q_count;
    logic [NB-1:0]                       evt;
    logic [NUM_USERS-1:0][NB-1:0]        u_status, u_enable;

    mbox_decode #(
        .NQ (NUM_QUEUES),
        .NU (NUM_USERS),
        .EXT(EXT_LAYOUT),
        .AW (ADDR_W)
    ) u_decode (
        .addr    (bus_addr),
        .rev_hit (rev_hit),
        .msg_hit (msg_hit),
        .fill_hit(fill_hit),
        .cnt_hit (cnt_hit),
        .stat_hit(stat_hit),
        .en_hit  (en_hit),
        .clr_hit (clr_hit)
    );

    assign q_push = {NUM_QUEUES{bus_wr}} & msg_hit;
    assign q_pop  = {NUM_QUEUES{bus_rd}} & msg_hit;

    // One queue per index, with its two event bits.
    for (genvar m = 0; m < NUM_QUEUES; m++) begin : g_queue
        mbox_fifo #(
            .DEPTH(FIFO_DEPTH),
            .DW   (32),
            .CW   (CW)
        ) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (q_push[m]),
            .pop    (q_pop[m]),
            .wdata  (bus_wdata),
            .head   (q_head[m]),
            .count  (q_count[m]),
            .full   (q_full[m]),
            .push_ok(q_push_ok[m]),
            .pop_ok (q_pop_ok[m])
        );
        assign evt[2*m]   = q_push_ok[m];
        assign evt[2*m+1] = q_pop_ok[m] & q_full[m];
    end

    // One interrupt block per user; all users see the same events.
    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        mbox_user_irq #(
            .NB (NB),
            .EXT(EXT_LAYOUT)
        ) u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt),
            .stat_wr(bus_wr & stat_hit[u]),
            .en_wr  (bus_wr & en_hit[u]),
            .clr_wr (bus_wr & clr_hit[u]),
            .wdata  (bus_wdata[NB-1:0]),
            .status (u_status[u]),
            .enable (u_enable[u]),
            .irq    (irq_out[u])
        );
    end

    // Read data mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (rev_hit) bus_rdata = REV_ID;
        for (int m = 0; m < NUM_QUEUES; m++) begin
            if (msg_hit[m])  bus_rdata = q_head[m];
            if (fill_hit[m]) bus_rdata = {31'b0, q_full[m]};
            if (cnt_hit[m])  bus_rdata = 32'(q_count[m]);
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (stat_hit[u])            bus_rdata[NB-1:0] = u_status[u];
            if (en_hit[u] | clr_hit[u]) bus_rdata[NB-1:0] = u_enable[u];
        end
    end
endmodule

// File: rtl/mbox_checker.sv
// Checker for mbox_ctrl: queue bounds, event setting, status clearing, irq gating.
// Attached to every mbox_ctrl instance by the bind at the end of this file.
module mbox_checker #(
    parameter int NQ    = 4,
    parameter int NU    = 2,
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int NB    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [NB-1:0]         wlow,
    input logic [NQ-1:0]         q_push,
    input logic [NQ-1:0]         q_pop,
    input logic [NQ-1:0][CW-1:0] q_count,
    input logic [NB-1:0]         evt,
    input logic [NU-1:0]         stat_hit,
    input logic [NU-1:0][NB-1:0] u_status,
    input logic [NU-1:0][NB-1:0] u_enable,
    input logic [NU-1:0]         irq_out
);
    for (genvar m = 0; m < NQ; m++) begin : g_q
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            q_count[m] <= CW'(DEPTH));
        a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (q_count[m] == CW'(DEPTH) && q_push[m] && !q_pop[m]) |=> q_count[m] == CW'(DEPTH));
        a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q_count[m] == '0 && q_pop[m] && !q_push[m]) |=> q_count[m] == '0);
        for (genvar u = 0; u < NU; u++) begin : g_u
            a_r5_newmsg_set: assert property (@(posedge clk) disable iff (!rst_n)
                (q_push[m] && q_count[m] != CW'(DEPTH)) |=> u_status[u][2*m]);
            a_r6_notfull_set: assert property (@(posedge clk) disable iff (!rst_n)
                (q_pop[m] && q_count[m] == CW'(DEPTH)) |=> u_status[u][2*m+1]);
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (u_enable[u] == '0) |-> !irq_out[u]);
        for (genvar b = 0; b < NB; b++) begin : g_bit
            a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && stat_hit[u] && wlow[b] && !evt[b]) |=> !u_status[u][b]);
        end
    end
endmodule

bind mbox_ctrl mbox_checker #(
    .NQ   (NUM_QUEUES),
    .NU   (NUM_USERS),
    .DEPTH(FIFO_DEPTH),
    .CW   (CW),
    .NB   (NB)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .wlow    (bus_wdata[NB-1:0]),
    .q_push  (q_push),
    .q_pop   (q_pop),
    .q_count (q_count),
    .evt     (evt),
    .stat_hit(stat_hit),
    .u_status(u_status),
    .u_enable(u_enable),
    .irq_out (irq_out)
);

// File: tb/mbox_ctrl_bench.sv
// Bench: runs the same sweep on a legacy-layout and an extended-layout instance.
module mbox_ctrl_bench;
    localparam int          NQ  = 4;
    localparam int          NU  = 2;
    localparam int          D   = 4;
    localparam logic [31:0] REV = 32'h0000_0021;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [8:0]    b_addr  [2];
    logic          b_wr    [2];
    logic          b_rd    [2];
    logic [31:0]   b_wdata [2];
    logic [31:0]   b_rdata [2];
    logic [NU-1:0] b_irq   [2];

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    mbox_ctrl #(.EXT_LAYOUT(1'b0)) u_mbox_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr[0]), .bus_wr(b_wr[0]),
        .bus_wdata(b_wdata[0]), .bus_rd(b_rd[0]), .bus_rdata(b_rdata[0]), .irq_out(b_irq[0])
    );
    mbox_ctrl #(.EXT_LAYOUT(1'b1)) u_mbox_ctrl_ext (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr[1]), .bus_wr(b_wr[1]),
        .bus_wdata(b_wdata[1]), .bus_rd(b_rd[1]), .bus_rdata(b_rdata[1]), .irq_out(b_irq[1])
    );

    function automatic int a_msg(input int m);  return 32'h40 + 4 * m; endfunction
    function automatic int a_fill(input int m); return 32'h80 + 4 * m; endfunction
    function automatic int a_cnt(input int m);  return 32'hC0 + 4 * m; endfunction
    function automatic int a_stat(input int x, input int u);
        return (x != 0) ? 32'h104 + 16 * u : 32'h100 + 8 * u;
    endfunction
    function automatic int a_en(input int x, input int u);
        return (x != 0) ? 32'h108 + 16 * u : 32'h104 + 8 * u;
    endfunction
    function automatic int a_clr(input int u); return 32'h10C + 16 * u; endfunction
    function automatic logic [31:0] msgval(input int x, input int m, input int i);
        return 32'hC0DE_0000 | 32'(x << 12) | 32'(m << 8) | 32'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int x, input int a, input logic [31:0] d);
        @(negedge clk);
        b_addr[x] = 9'(a); b_wdata[x] = d; b_wr[x] = 1'b1;
        @(negedge clk);
        b_wr[x] = 1'b0;
    endtask

    task automatic rd(input int x, input int a, output logic [31:0] d);
        @(negedge clk);
        b_addr[x] = 9'(a); b_rd[x] = 1'b1;
        #4 d = b_rdata[x];
        @(negedge clk);
        b_rd[x] = 1'b0;
    endtask

    // Both strobes on one address in the same cycle.
    task automatic wrrd(input int x, input int a, input logic [31:0] wd, output logic [31:0] d);
        @(negedge clk);
        b_addr[x] = 9'(a); b_wdata[x] = wd; b_wr[x] = 1'b1; b_rd[x] = 1'b1;
        #4 d = b_rdata[x];
        @(negedge clk);
        b_wr[x] = 1'b0; b_rd[x] = 1'b0;
    endtask

    task automatic run_layout(input int x);
        logic [31:0] d;
        // R11 reset state and R1 revision
        rd(x, 0, d); chk("R1 revision", d, REV);
        wr(x, 0, 32'hFFFF_FFFF);
        rd(x, 0, d); chk("R1 revision after write", d, REV);
        for (int m = 0; m < NQ; m++) begin
            rd(x, a_cnt(m), d);  chk("R11 count after reset", d, 0);
            rd(x, a_fill(m), d); chk("R11 fill after reset", d, 0);
        end
        for (int u = 0; u < NU; u++) begin
            rd(x, a_stat(x, u), d); chk("R11 status after reset", d, 0);
            rd(x, a_en(x, u), d);   chk("R11 enable after reset", d, 0);
        end
        chk("R11 irq after reset", 32'(b_irq[x]), 0);

        // R2 R3 R5 pushes, one beyond capacity
        for (int m = 0; m < NQ; m++) begin
            for (int i = 0; i <= D; i++) begin
                wr(x, a_msg(m), msgval(x, m, i));
                rd(x, a_cnt(m), d);  chk("R3 R4 count while filling", d, (i + 1 < D) ? i + 1 : D);
                rd(x, a_fill(m), d); chk("R3 fill flag", d, (i + 1 >= D) ? 1 : 0);
            end
            for (int u = 0; u < NU; u++) begin
                rd(x, a_stat(x, u), d);
                chk("R5 new-message bit", 32'(d[2*m]), 1);
                chk("R6 not-full bit before pop", 32'(d[2*m+1]), 0);
            end
        end

        // R2 R4 R6 pops, one beyond empty
        for (int m = 0; m < NQ; m++) begin
            for (int i = 0; i <= D; i++) begin
                rd(x, a_msg(m), d);
                chk("R2 R4 popped word", d, (i < D) ? msgval(x, m, i) : 32'h0);
                rd(x, a_cnt(m), d);
                chk("R4 count while draining", d, (D - 1 - i > 0) ? D - 1 - i : 0);
            end
            for (int u = 0; u < NU; u++) begin
                rd(x, a_stat(x, u), d); chk("R6 not-full bit after pop", 32'(d[2*m+1]), 1);
            end
        end
        for (int u = 0; u < NU; u++) begin
            rd(x, a_stat(x, u), d); chk("R5 R6 all events", d, 32'hFF);
        end

        // R7 write-one-to-clear
        wr(x, a_stat(x, 0), 32'h05);
        rd(x, a_stat(x, 0), d); chk("R7 partial clear", d, 32'hFA);
        rd(x, a_stat(x, 1), d); chk("R7 other user untouched", d, 32'hFF);

        // R8 R9 R10 enables and irq
        if (x == 0) begin
            wr(x, a_en(x, 0), 32'h02);
            rd(x, a_en(x, 0), d); chk("R8 enable readback", d, 32'h02);
            chk("R10 irq user0 on", 32'(b_irq[x][0]), 1);
            chk("R10 irq user1 off", 32'(b_irq[x][1]), 0);
            wr(x, a_en(x, 0), 32'h00);
            rd(x, a_en(x, 0), d); chk("R8 enable rewritten", d, 0);
            chk("R10 irq off after disable", 32'(b_irq[x][0]), 0);
        end else begin
            wr(x, a_en(x, 0), 32'h02);
            wr(x, a_en(x, 0), 32'h08);
            rd(x, a_en(x, 0), d); chk("R9 set ORs bits", d, 32'h0A);
            rd(x, a_clr(0), d);   chk("R9 clear address reads enable", d, 32'h0A);
            wr(x, a_clr(0), 32'h02);
            rd(x, a_en(x, 0), d); chk("R9 clear removes ones only", d, 32'h08);
            chk("R10 irq user0 on", 32'(b_irq[x][0]), 1);
            chk("R10 irq user1 off", 32'(b_irq[x][1]), 0);
            wr(x, a_clr(0), 32'h08);
            rd(x, a_en(x, 0), d); chk("R9 enable cleared", d, 0);
            chk("R10 irq off after clear", 32'(b_irq[x][0]), 0);
        end

        wr(x, a_stat(x, 0), 32'hFF);
        rd(x, a_stat(x, 0), d); chk("R7 full clear", d, 0);
        wr(x, a_en(x, 0), 32'hFF);
        chk("R10 no irq with empty status", 32'(b_irq[x][0]), 0);
        wr(x, a_msg(2), 32'h1234_5678);
        chk("R10 irq raised by new message", 32'(b_irq[x][0]), 1);
        chk("R10 irq masked for user1", 32'(b_irq[x][1]), 0);
        rd(x, a_msg(2), d); chk("R2 single word", d, 32'h1234_5678);
        rd(x, a_stat(x, 0), d); chk("R6 no not-full from partial queue", d, 32'h10);
        wr(x, a_stat(x, 0), 32'hFF);
        chk("R10 irq dropped after ack", 32'(b_irq[x][0]), 0);
        if (x == 0) wr(x, a_en(x, 0), 32'h00); else wr(x, a_clr(0), 32'hFF);

        // R13 push and pop together on a full queue
        for (int i = 0; i < D; i++) wr(x, a_msg(1), msgval(x, 1, i));
        wr(x, a_stat(x, 0), 32'hFF);
        wrrd(x, a_msg(1), 32'hDEAD_BEEF, d);
        chk("R13 full queue pops oldest", d, msgval(x, 1, 0));
        rd(x, a_cnt(1), d);     chk("R13 full queue count", d, D - 1);
        rd(x, a_stat(x, 0), d); chk("R13 full queue events", d, 32'h08);
        for (int i = 1; i < D; i++) begin
            rd(x, a_msg(1), d); chk("R13 dropped push absent", d, msgval(x, 1, i));
        end
        rd(x, a_cnt(1), d); chk("R13 drained", d, 0);

        // R13 push and pop together on an empty queue
        wr(x, a_stat(x, 0), 32'hFF);
        wrrd(x, a_msg(3), 32'h0BAD_F00D, d);
        chk("R13 empty queue returns zero", d, 0);
        rd(x, a_cnt(3), d);     chk("R13 empty queue count", d, 1);
        rd(x, a_stat(x, 0), d); chk("R13 empty queue events", d, 32'h40);
        rd(x, a_msg(3), d);     chk("R13 pushed word kept", d, 32'h0BAD_F00D);

        // R12 unmapped and read-only registers
        rd(x, 32'h020, d); chk("R12 unmapped reads zero", d, 0);
        wr(x, 32'h020, 32'hFFFF_FFFF);
        rd(x, 32'h020, d); chk("R12 unmapped ignores write", d, 0);
        rd(x, 32'h050, d); chk("R12 beyond last queue", d, 0);
        wr(x, a_cnt(0), 32'h3);
        rd(x, a_cnt(0), d); chk("R12 count ignores write", d, 0);
        wr(x, a_fill(0), 32'h1);
        rd(x, a_fill(0), d); chk("R12 fill ignores write", d, 0);
    endtask

    initial begin
        for (int x = 0; x < 2; x++) begin
            b_addr[x] = '0; b_wr[x] = 1'b0; b_rd[x] = 1'b0; b_wdata[x] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int x = 0; x < 2; x++) run_layout(x);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule